// File: doc/BRIEF.md
# UART Transmitter with Busy Tracking

This block is the transmit half of a UART. Bytes written by a host land in a 16-entry FIFO. A framing state machine takes them one at a time and sends each as an asynchronous serial character on a line that idles high. The character length, the parity mode and the stop-bit count come from a five-bit line-configuration input. That input is captured when a character starts, so a change made during a character affects only later characters. Bit timing comes from an external baud tick that runs at 16 or 8 times the bit rate, chosen by a fast-mode input. The divider that makes the tick is not part of this block.

While the enable input is high and the FIFO holds data, characters go out back to back with no idle gap between them. The busy output covers all transmit activity. It rises on the first accepted write, and it stays high until the FIFO is empty and the last stop bit has finished. Dropping the enable input stops new characters from starting, but a character already on the line always finishes. Busy therefore stays high while the block is disabled and data is still waiting. The full and empty flags show FIFO occupancy. A write that arrives while the FIFO is full is discarded.

The framer has five named states:
- `ST_IDLE`: the line is high.
- `ST_START`: the line is low.
- `ST_DATA`: data bits go out LSB first.
- `ST_PARITY`: the parity bit goes out.
- `ST_STOP`: the line is high.

Its transitions are:
- IDLE→START: enabled and the FIFO is not empty; this pops one byte.
- START→DATA: at the end of the bit.
- DATA→PARITY: at the end of the last data bit, when parity is on.
- DATA→STOP: at the end of the last data bit, when parity is off.
- PARITY→STOP: at the end of the bit.
- STOP→STOP: at the end of the first stop bit, when two stop bits are configured.
- STOP→START: at the end of the final stop bit, when enabled and the FIFO is not empty; this pops the next byte with no gap.
- STOP→IDLE: at the end of the final stop bit otherwise.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset, `tx` is 1, `busy` is 0, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: The FIFO holds 16 bytes. `fifo_full` is 1 after 16 unread accepted writes. A write while `fifo_full` is 1 is discarded and is never transmitted.
- R3: A character is one low start bit, then N data bits LSB first. N = `line_cfg[1:0]` + 5, so codes 0..3 give 5..8 bits. Data bits above N are ignored. The line idles high.
- R4: When `line_cfg[2]` = 1, a parity bit follows the data bits. `line_cfg[3]` = 1 selects odd parity and 0 selects even parity, computed over the N data bits only.
- R5: The stop bits are high. `line_cfg[4]` = 1 sends two stop bits and 0 sends one.
- R6: Each bit lasts 16 baud ticks when `fast_mode` = 0 and 8 ticks when `fast_mode` = 1. A bit ends on a tick edge.
- R7: While `enable` is 1 and the FIFO is not empty, the next start bit begins in the cycle right after the previous final stop bit ends.
- R8: No character starts while `enable` is 0. A character that is in progress when `enable` falls completes in full.
- R9: `busy` is 1 in the cycle after an accepted write.
- R10: `busy` stays 1 while the FIFO is non-empty or a character is on the line, including while `enable` is 0. It falls only after the final stop bit ends with the FIFO empty.
- R11: `line_cfg` and `fast_mode` are sampled when a character starts. Changes made during the character do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows new characters to start |
| fast_mode | input | 1 | 1: 8 ticks per bit, 0: 16 ticks per bit |
| line_cfg | input | 5 | [1:0] length code, [2] parity on, [3] odd parity, [4] two stop bits |
| baud_tick | input | 1 | One-cycle oversampling tick |
| wr_en | input | 1 | Write strobe for the FIFO |
| wr_data | input | 8 | Byte to queue |
| tx | output | 1 | Serial output, idles high |
| busy | output | 1 | Transmit activity flag |
| fifo_full | output | 1 | FIFO holds 16 bytes |
| fifo_empty | output | 1 | FIFO holds no bytes |

## Verification
A scoreboard decodes every character from the line at each baud tick. It checks each bit against its position in the expected frame, so a design that counted the wrong number of ticks per bit, sent bits MSB first, or computed parity over bits beyond the character length would show a mismatch. The bench counts start bits that begin in the cycle right after a stop bit. A framer that passed through idle between queued characters would therefore come up short on that count. Enable is dropped in the middle of a character: a design that cut the character short would fail the frame check, and one that cleared busy while data was still waiting would fail the busy check. The bench also overfills the FIFO and changes the line configuration during a character, which catches a FIFO that accepts a 17th byte and a framer that reads the configuration live instead of latching it.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic       two_stop;
        logic       par_odd;
        logic       par_en;
        logic [1:0] len_code;
    } line_cfg_t;

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          full,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
    parameter int OS_SLOW = 16,
    parameter int OS_FAST = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    input  logic baud_tick,
    output logic bit_done
);
    localparam int CW = $clog2(OS_SLOW);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last     = fast ? CW'(OS_FAST - 1) : CW'(OS_SLOW - 1);
    assign bit_done = run && baud_tick && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (!run)      cnt <= '0;
        else if (baud_tick) cnt <= bit_done ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  line_cfg_t         cfg_in,
    input  logic              fast_in,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_data,
    input  logic              bit_done,
    output logic              pop,
    output logic              active,
    output logic              fast_q,
    output logic              tx
);
    localparam int IW = $clog2(CHAR_W);

    tx_state_e         state, state_n;
    line_cfg_t         cfg_q;
    logic [CHAR_W-1:0] shreg;
    logic [IW-1:0]     bit_idx;
    logic              stop_idx;
    logic              par_q;

    logic              can_load, data_last, last_stop, par_new;
    logic [CHAR_W-1:0] char_mask;

    assign can_load  = enable && !fifo_empty;
    assign data_last = ({1'b0, bit_idx} == (4'(cfg_q.len_code) + 4'd4));
    assign last_stop = !cfg_q.two_stop || stop_idx;
    assign char_mask = {CHAR_W{1'b1}} >> (2'd3 - cfg_in.len_code);
    assign par_new   = (^(fifo_data & char_mask)) ^ cfg_in.par_odd;
    assign active    = (state != ST_IDLE);

    // next state and FIFO pop
    always_comb begin
        state_n = state;
        pop     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (can_load) begin
                    state_n = ST_START;
                    pop     = 1'b1;
                end
            end
            ST_START:  if (bit_done) state_n = ST_DATA;
            ST_DATA: begin
                if (bit_done && data_last)
                    state_n = cfg_q.par_en ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: if (bit_done) state_n = ST_STOP;
            ST_STOP: begin
                if (bit_done && last_stop) begin
                    if (can_load) begin
                        state_n = ST_START;
                        pop     = 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // character datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            fast_q   <= 1'b0;
            shreg    <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            par_q    <= 1'b0;
        end else if (pop) begin
            cfg_q    <= cfg_in;
            fast_q   <= fast_in;
            shreg    <= fifo_data;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            par_q    <= par_new;
        end else if (bit_done) begin
            if (state == ST_DATA) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end
            if (state == ST_STOP && !last_stop) stop_idx <= 1'b1;
        end
    end

    // line output
    always_comb begin
        unique case (state)
            ST_IDLE:   tx = 1'b1;
            ST_START:  tx = 1'b0;
            ST_DATA:   tx = shreg[0];
            ST_PARITY: tx = par_q;
            ST_STOP:   tx = 1'b1;
            default:   tx = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
    import uart_tx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int OS_SLOW    = 16,
    parameter int OS_FAST    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              fast_mode,
    input  logic [4:0]        line_cfg,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    output logic              tx,
    output logic              busy,
    output logic              fifo_full,
    output logic              fifo_empty
);
    logic              pop, active, fast_q, bit_done;
    logic [CHAR_W-1:0] head;

    uart_tx_fifo #(.DW(CHAR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    uart_tx_bit_timer #(.OS_SLOW(OS_SLOW), .OS_FAST(OS_FAST)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (active),
        .fast      (fast_q),
        .baud_tick (baud_tick),
        .bit_done  (bit_done)
    );

    uart_tx_framer u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .cfg_in     (line_cfg_t'(line_cfg)),
        .fast_in    (fast_mode),
        .fifo_empty (fifo_empty),
        .fifo_data  (head),
        .bit_done   (bit_done),
        .pop        (pop),
        .active     (active),
        .fast_q     (fast_q),
        .tx         (tx)
    );

    assign busy = active || !fifo_empty;
endmodule

// File: rtl/uart_tx_checks.sv
module uart_tx_checks (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic baud_tick,
    input logic tx,
    input logic busy,
    input logic fifo_full,
    input logic fifo_empty
);
    a_r9_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !fifo_full) |=> busy);

    a_r10_busy_covers_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_empty |-> busy);

    a_r10_busy_falls_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(baud_tick));

    a_r3_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx);

    a_r2_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    a_r6_low_holds_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && !tx) |=> !tx);
endmodule

bind uart_tx_engine uart_tx_checks u_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .baud_tick  (baud_tick),
    .tx         (tx),
    .busy       (busy),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty)
);

// File: tb/tb_uart_tx_engine.sv
module tb_uart_tx_engine;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       fast_mode = 1'b0;
    logic [4:0] line_cfg = 5'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h0;
    logic       tx, busy, fifo_full, fifo_empty;

    int checks = 0;
    int errors = 0;
    int frames_seen = 0;
    int b2b_count = 0;
    int tick_period = 1;

    typedef struct {
        logic [7:0] d;
        logic [4:0] c;
        logic       f;
    } item_t;
    item_t exp_q[$];

    uart_tx_engine dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
        .line_cfg(line_cfg), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .tx(tx), .busy(busy), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // baud tick source, changed just after the rising edge
    initial begin
        int ctr = 0;
        forever begin
            @(posedge clk);
            #1;
            ctr++;
            if (ctr >= tick_period) begin
                baud_tick = 1'b1;
                ctr = 0;
            end else begin
                baud_tick = 1'b0;
            end
        end
    end

    // driver: queue the expected character, then write it
    task automatic write_byte(input logic [7:0] d, input bit accept);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        if (accept) exp_q.push_back('{d: d, c: line_cfg, f: fast_mode});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // monitor: decode every character at each tick and compare with the queue
    initial begin
        bit          pending = 0;
        item_t       it;
        logic [11:0] bits;
        int          nb, blen, idx, nd, bad_at;
        logic        bad_val;
        forever begin
            if (!pending) @(negedge clk);
            pending = 0;
            if (rst_n && !tx) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2 R8 unexpected start bit", 1, 0);
                    it = '{d: 8'h0, c: 5'h0, f: 1'b0};
                end else begin
                    it = exp_q.pop_front();
                end
                nd = int'(it.c[1:0]) + 5;
                bits = 12'hFFF;
                bits[0] = 1'b0;
                for (int i = 0; i < nd; i++) bits[1+i] = it.d[i];
                nb = 1 + nd;
                if (it.c[2]) begin
                    logic p;
                    p = it.c[3];
                    for (int i = 0; i < nd; i++) p = p ^ it.d[i];
                    bits[nb] = p;
                    nb++;
                end
                nb += it.c[4] ? 2 : 1;
                blen = it.f ? 8 : 16;
                idx = 0;
                bad_at = -1;
                bad_val = 1'b0;
                forever begin
                    if (baud_tick) begin
                        idx++;
                        if (tx !== bits[(idx-1)/blen] && bad_at < 0) begin
                            bad_at = (idx-1)/blen;
                            bad_val = tx;
                        end
                        if (idx == nb*blen) break;
                    end
                    @(negedge clk);
                end
                // R3 R4 R5 R6: every bit of the frame matched at every tick
                check(bad_at < 0, $sformatf("R3 R4 R5 R6 frame %0h bit %0d", it.d, bad_at),
                      32'(bad_val), 32'(bits[(bad_at < 0) ? 0 : bad_at]));
                check(busy == 1'b1, "R10 busy during final stop bit", 32'(busy), 1);
                frames_seen++;
                @(posedge clk);
                @(negedge clk);
                if (!tx) begin
                    b2b_count++;
                    pending = 1;
                end
            end
        end
    end

    task automatic wait_idle();
        int guard = 0;
        @(negedge clk);
        while (busy && guard < 40000) begin
            @(negedge clk);
            guard++;
        end
        check(!busy, "R10 busy clears after drain", 32'(busy), 0);
        check(exp_q.size() == 0, "R10 all queued characters sent before busy fell", exp_q.size(), 0);
        check(tx && fifo_empty, "R3 line high and FIFO empty when idle", {tx, fifo_empty}, 2'b11);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base;
        int b2b_base;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tx == 1 && busy == 0 && fifo_empty == 1 && fifo_full == 0,
              "R1 reset outputs", {tx, busy, fifo_empty, fifo_full}, 4'b1010);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // 8 data bits, no parity, one stop bit, 16x (R3 R6 R9)
        enable = 1'b1; fast_mode = 1'b0; line_cfg = 5'b0_0_0_11; tick_period = 1;
        check(busy == 0, "R9 busy low before write", 32'(busy), 0);
        write_byte(8'hA5, 1);
        check(busy == 1, "R9 busy high after write", 32'(busy), 1);
        wait_idle();
        check(frames_seen == 1, "R3 one frame sent", frames_seen, 1);

        // 5 bits, even parity, two stops, 8x, slow ticks; back to back (R4 R5 R7)
        fast_mode = 1'b1; line_cfg = 5'b1_0_1_00; tick_period = 3;
        b2b_base = b2b_count;
        write_byte(8'h13, 1);
        write_byte(8'hFE, 1);
        wait_idle();
        check(b2b_count - b2b_base == 1, "R7 back-to-back start", b2b_count - b2b_base, 1);

        // 7 bits, odd parity, one stop, 16x (R4 R7)
        fast_mode = 1'b0; line_cfg = 5'b0_1_1_10; tick_period = 2;
        b2b_base = b2b_count;
        write_byte(8'h55, 1);
        write_byte(8'h00, 1);
        write_byte(8'hFF, 1);
        wait_idle();
        check(b2b_count - b2b_base == 2, "R7 three characters without gap", b2b_count - b2b_base, 2);

        // 6 bits, no parity, two stops, 8x (R5 R6)
        fast_mode = 1'b1; line_cfg = 5'b1_0_0_01; tick_period = 1;
        write_byte(8'h2A, 1);
        wait_idle();

        // disabled: nothing starts, busy held (R8 R10)
        enable = 1'b0;
        base = frames_seen;
        write_byte(8'h99, 1);
        repeat (300) @(negedge clk);
        check(frames_seen == base && tx == 1, "R8 no start while disabled", frames_seen - base, 0);
        check(busy == 1, "R10 busy held while disabled with data", 32'(busy), 1);
        enable = 1'b1;
        wait_idle();
        check(frames_seen == base + 1, "R8 sent after enable", frames_seen - base, 1);

        // disable in the middle of a character (R8 R10)
        fast_mode = 1'b0; line_cfg = 5'b0_0_0_11;
        base = frames_seen;
        write_byte(8'h81, 1);
        write_byte(8'h42, 1);
        while (tx) @(negedge clk);
        repeat (5) @(negedge clk);
        enable = 1'b0;
        while (frames_seen == base) @(negedge clk);
        repeat (400) @(negedge clk);
        check(frames_seen == base + 1, "R8 in-progress frame completes, next held", frames_seen - base, 1);
        check(busy == 1 && fifo_empty == 0, "R10 busy while disabled and pending", {busy, fifo_empty}, 2'b10);
        enable = 1'b1;
        wait_idle();
        check(frames_seen == base + 2, "R8 pending byte sent on re-enable", frames_seen - base, 2);

        // overfill (R2)
        enable = 1'b0; fast_mode = 1'b1; line_cfg = 5'b0_0_0_11;
        base = frames_seen;
        for (int i = 0; i < 16; i++) write_byte(8'(i*7 + 1), 1);
        check(fifo_full == 1, "R2 full after 16 writes", 32'(fifo_full), 1);
        write_byte(8'hEE, 0);
        check(fifo_full == 1, "R2 still full after dropped write", 32'(fifo_full), 1);
        enable = 1'b1;
        wait_idle();
        check(frames_seen == base + 16, "R2 only 16 characters sent", frames_seen - base, 16);

        // configuration changed during a character (R11)
        fast_mode = 1'b0; line_cfg = 5'b0_0_0_11;
        base = frames_seen;
        write_byte(8'h3C, 1);
        while (tx) @(negedge clk);
        fast_mode = 1'b1; line_cfg = 5'b1_1_1_00;
        write_byte(8'h0B, 1);
        wait_idle();
        check(frames_seen == base + 2, "R11 both characters sent with own settings", frames_seen - base, 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule